// File: doc/BRIEF.md
# Morse Letter Flasher

This block blinks a single output in Morse code for one of eight consecutive letters, Q through X, chosen by a 3-bit code. A one-cycle start request, taken while the block is idle, captures the code and begins the letter. Each dot lights the output for one half-second unit. Each dash lights it for three units. Symbols within a letter are separated by one dark unit. The length of a unit comes from a parameter that gives the clock frequency, so a bench can use a short unit.

The datapath has four parts. A decoder gives a left-justified four-bit symbol pattern, in which 1 means dash and 0 means dot, together with a two-bit count equal to the number of symbols minus one. A shift register presents the current symbol at its top bit. A down counter tracks how many symbols remain. A half-second timer raises a one-cycle tick and is cleared whenever a lit pulse begins.

A controller sequences these parts. Its states are IDLE, DOT, DASH1, DASH2, DASH3 and GAP, and it moves between them as follows:
- accept: IDLE to DOT or DASH1 on start, chosen by the decoded first symbol. The pattern and count are loaded and the timer is cleared.
- dash_step: DASH1 to DASH2, and DASH2 to DASH3, on a tick.
- symbol_end: DOT or DASH3 on a tick. The controller goes to GAP with a shift and a decrement when the counter is non-zero, and it goes to IDLE (finish) when the counter is zero.
- resume: GAP to DOT or DASH1 on a tick, chosen by the new top bit, with the timer cleared.

Top module: `morse_flasher`

## Requirements
- R1: An active-low asynchronous reset forces `led` and `busy` low at once, without waiting for a clock edge, and returns the controller to IDLE.
- R2: The code values map to these patterns: 0 = Q (dash dash dot dash), 1 = R (dot dash dot), 2 = S (dot dot dot), 3 = T (dash), 4 = U (dot dot dash), 5 = V (dot dot dot dash), 6 = W (dot dash dash), 7 = X (dash dot dot dash).
- R3: A high `start` at a clock edge while idle captures `letter` at that edge. `busy` and the first lit pulse both begin in the following cycle.
- R4: A dot holds `led` high for exactly HALF cycles and a dash holds it high for exactly 3*HALF cycles, where HALF = CLK_HZ/2.
- R5: Consecutive symbols are separated by exactly HALF cycles with `led` low while `busy` stays high. No gap follows the last symbol: `busy` and `led` are low in the cycle right after the last pulse ends.
- R6: Symbols are sent in order from the most significant bit of the left-justified pattern (bit 3) downward.
- R7: While `busy` is high, `start` and changes on `letter` have no effect on the waveform being sent.
- R8: The timer gives a single-cycle tick every HALF cycles after it is cleared, and it is cleared at the start of every lit pulse.
- R9: The symbol counter is loaded with the symbol count minus one, is decremented only between symbols, and the letter ends when it reads zero, so it never underflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a letter; used only when idle |
| letter | input | 3 | Letter select, 0 = Q through 7 = X |
| led | output | 1 | Morse output, high while a dot or dash is lit |
| busy | output | 1 | High while a letter is being sent |

## Verification
The assertions assume that `start` and `letter` are synchronous to `clk` and settle well away from the rising edge. They also assume that reset is released away from an edge and that CLK_HZ gives HALF of at least two, so that ticks cannot come back to back. The bench drives every input on the falling edge and releases reset there, and it uses HALF = 4. It deliberately toggles `start` and `letter` during a letter to show that requests arriving while busy are dropped.

// File: rtl/morse_pkg.sv
package morse_pkg;

    localparam int CODE_W  = 3;
    localparam int SYM_MAX = 4;
    localparam int CNT_W   = $clog2(SYM_MAX);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DOT   = 3'd1,
        ST_DASH1 = 3'd2,
        ST_DASH2 = 3'd3,
        ST_DASH3 = 3'd4,
        ST_GAP   = 3'd5
    } flash_state_e;

endpackage

// File: rtl/morse_decode.sv
module morse_decode
    import morse_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    output logic [SYM_MAX-1:0] pat_o,
    output logic [CNT_W-1:0]   cnt_o
);

    // Pattern is left-justified: bit SYM_MAX-1 is sent first, 1 = dash.
    always_comb begin
        pat_o = '0;
        cnt_o = '0;
        unique case (code_i)
            3'd0: begin pat_o = 4'b1101; cnt_o = 2'd3; end
            3'd1: begin pat_o = 4'b0100; cnt_o = 2'd2; end
            3'd2: begin pat_o = 4'b0000; cnt_o = 2'd2; end
            3'd3: begin pat_o = 4'b1000; cnt_o = 2'd0; end
            3'd4: begin pat_o = 4'b0010; cnt_o = 2'd2; end
            3'd5: begin pat_o = 4'b0001; cnt_o = 2'd3; end
            3'd6: begin pat_o = 4'b0110; cnt_o = 2'd2; end
            3'd7: begin pat_o = 4'b1001; cnt_o = 2'd3; end
            default: begin pat_o = '0; cnt_o = '0; end
        endcase
    end

endmodule

// File: rtl/morse_symreg.sv
module morse_symreg
    import morse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [SYM_MAX-1:0] pat_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic               head_o,
    output logic               zero_o
);

    logic [SYM_MAX-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            sr_q  <= pat_i;
            cnt_q <= cnt_i;
        end else if (shift_i) begin
            sr_q  <= {sr_q[SYM_MAX-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head_o = sr_q[SYM_MAX-1];
    assign zero_o = (cnt_q == '0);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/morse_tick.sv
module morse_tick #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int HALF = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
    localparam int TW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (HALF > 1) begin : g_tick_chk
            // R8
            single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
            // R8
            clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/morse_ctrl.sv
module morse_ctrl
    import morse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic first_dash_i,
    input  logic head_i,
    input  logic tick_i,
    input  logic zero_i,
    output logic load_o,
    output logic shift_o,
    output logic tmr_clr_o,
    output logic led_o,
    output logic busy_o
);

    flash_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        load_o    = 1'b0;
        shift_o   = 1'b0;
        tmr_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load_o    = 1'b1;
                    tmr_clr_o = 1'b1;
                    state_d   = first_dash_i ? ST_DASH1 : ST_DOT;
                end
            end
            ST_DASH1: if (tick_i) state_d = ST_DASH2;
            ST_DASH2: if (tick_i) state_d = ST_DASH3;
            ST_DOT, ST_DASH3: begin
                if (tick_i) begin
                    if (zero_i) begin
                        state_d = ST_IDLE;
                    end else begin
                        shift_o = 1'b1;
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    tmr_clr_o = 1'b1;
                    state_d   = head_i ? ST_DASH1 : ST_DOT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        led_o  = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:                               busy_o = 1'b0;
            ST_DOT, ST_DASH1, ST_DASH2, ST_DASH3:  led_o  = 1'b1;
            ST_GAP:                                led_o  = 1'b0;
            default: begin led_o = 1'b0; busy_o = 1'b0; end
        endcase
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));
    // R4
    dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOT && !tick_i) |=> (state_q == ST_DOT && led_o));
    // R5
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && !tick_i) |=> (state_q == ST_GAP && !led_o && busy_o));
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DASH2 && start_i && !tick_i) |=> (state_q == ST_DASH2));

endmodule

// File: rtl/morse_flasher.sv
module morse_flasher
    import morse_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] letter,
    output logic              led,
    output logic              busy
);

    logic [SYM_MAX-1:0] dec_pat;
    logic [CNT_W-1:0]   dec_cnt;
    logic               load, shift, tmr_clr, tick, head, zero;

    morse_decode u_dec (
        .code_i (letter),
        .pat_o  (dec_pat),
        .cnt_o  (dec_cnt)
    );

    morse_symreg u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .pat_i   (dec_pat),
        .cnt_i   (dec_cnt),
        .head_o  (head),
        .zero_o  (zero)
    );

    morse_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_o (tick)
    );

    morse_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .first_dash_i (dec_pat[SYM_MAX-1]),
        .head_i       (head),
        .tick_i       (tick),
        .zero_i       (zero),
        .load_o       (load),
        .shift_o      (shift),
        .tmr_clr_o    (tmr_clr),
        .led_o        (led),
        .busy_o       (busy)
    );

    // R5
    led_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led |-> busy);

endmodule

// File: tb/sim_morse_flasher.sv
module sim_morse_flasher;

    localparam int CLK_PERIOD = 10;
    localparam int SIM_HZ     = 8;
    localparam int HALF       = SIM_HZ / 2;

    // Expected patterns per code, bit 3 first, 1 = dash; and symbol counts.
    localparam logic [3:0] SYM_TAB [8] = '{4'b1101, 4'b0100, 4'b0000, 4'b1000,
                                           4'b0010, 4'b0001, 4'b0110, 4'b1001};
    localparam int         LEN_TAB [8] = '{4, 3, 3, 1, 3, 4, 3, 4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] letter = 3'd0;
    logic       led, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    morse_flasher #(.CLK_HZ(SIM_HZ)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .letter (letter),
        .led    (led),
        .busy   (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_letter(input logic [2:0] code, input bit disturb);
        int bad = 0;
        int first = -1;
        logic [3:0] syms = SYM_TAB[code];
        int n = LEN_TAB[code];
        @(negedge clk);
        letter = code;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        // R3: first lit cycle right after the accepting edge
        check(led === 1'b1 && busy === 1'b1, "R3 first cycle led/busy", int'({led, busy}), 3);
        for (int i = 0; i < n; i++) begin
            int ml = syms[3-i] ? 3*HALF : HALF;
            for (int c = 0; c < ml; c++) begin
                if (led !== 1'b1 || busy !== 1'b1) begin bad++; if (first < 0) first = int'({led, busy}); end
                if (disturb) begin start = 1'b1; letter = ~code; end
                @(negedge clk);
                start = 1'b0;
            end
            if (i < n - 1) begin
                for (int c = 0; c < HALF; c++) begin
                    if (led !== 1'b0 || busy !== 1'b1) begin bad++; if (first < 0) first = int'({led, busy}); end
                    if (disturb) begin start = 1'b1; letter = code + 3'd1; end
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        end
        // R2 R4 R6 pattern and pulse lengths; R7 when disturbed; R8 unit length
        check(bad == 0, disturb ? "R7 waveform under busy start" : "R2 R4 R6 R8 waveform",
              bad, 0);
        // R5 R9: no trailing gap, idle right after last pulse
        check(led === 1'b0 && busy === 1'b0, "R5 R9 idle after last symbol",
              int'({led, busy}), 0);
        letter = 3'd0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        #(CLK_PERIOD/4);
        // R1 reset state
        check(led === 1'b0 && busy === 1'b0, "R1 reset state", int'({led, busy}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(led === 1'b0 && busy === 1'b0, "R1 idle after release", int'({led, busy}), 0);

        // Vector walk over all eight codes (R2, R4, R5, R6, R8, R9)
        for (int k = 0; k < 8; k++) begin
            run_letter(3'(k), 1'b0);
        end

        // R7: start pulses and code changes while busy
        run_letter(3'd2, 1'b1);
        run_letter(3'd3, 1'b1);

        // R1: asynchronous reset in the middle of a letter
        @(negedge clk);
        letter = 3'd0;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (5) @(negedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check(led === 1'b0 && busy === 1'b0, "R1 async reset mid letter", int'({led, busy}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(led === 1'b0 && busy === 1'b0, "R1 stays idle after reset", int'({led, busy}), 0);
        run_letter(3'd7, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule